// File: doc/BRIEF.md
# UART Interrupt Request Controller

This block produces the two interrupt lines of a UART port. The port runs in one of two modes, chosen by the `dma_mode` input. In word mode the processor moves every character itself. In block mode a DMA engine moves the data and reports when it has finished. The block watches four kinds of input:

- the transmit-holding-empty status level,
- the receive-buffer-full status level,
- one completion strobe for each direction,
- a receive error strobe.

Software reaches an enable register, an identification register, a status register and the data address through a small register bus. The serial shifters and the DMA engine sit outside the block. Writes and reads at the data address count only as clearing events here.

Two request state machines follow the word sources, one for receive-full and one for transmit-empty. They are built from the same module. Each machine has three states:

- `SRC_OFF`: the source is disabled, or the port is in block mode.
- `SRC_WAIT`: the source is armed and waiting for a rising edge of its status level.
- `SRC_REQ`: a request is pending.

The transitions are:

- **enable-on**: `SRC_OFF` to `SRC_REQ` if the level is already high, or to `SRC_WAIT` if it is low.
- **arm**: `SRC_WAIT` to `SRC_REQ` on a rising level.
- **service**: `SRC_REQ` to `SRC_WAIT` on a clear with no rising level in the same cycle.
- **disable**: any state to `SRC_OFF` when the effective enable is low.

In word mode every request is ORed onto the receive line. In block mode the receive line carries DMA completion and errors, and the status bits tell the two apart.

Register map, on a 2-bit address:

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | enable | read/write | bit 0 receive-full enable, bit 1 transmit-empty enable, bit 2 error enable |
| 1 | identification | read-only | code in bits 1:0 |
| 2 | status | read, clears on read | bit 0 error, bit 1 receive DMA done, bit 2 transmit DMA done |
| 3 | data | strobes only | a write is a holding-register write, a read is a receive-buffer read; reads return zero |

Top module: `uirq_ctrl`

## Requirements
- R1: After a synchronous reset, both interrupt outputs are low, the enable, identification and status registers read 0, and the data address reads 0.
- R2: In word mode (`dma_mode`=0), every pending request drives `irq_rx`, and `irq_tx` stays low.
- R3: A word source latches a request only on a rising edge of its status level while its enable bit is set. An error drives the receive line only while enable bit 2 is set. The status bit 0 is still recorded when that enable is clear.
- R4: Setting enable bit 1 while `thr_empty` is already high raises the transmit-empty request without waiting for a new edge.
- R5: The transmit-empty request clears on a write to address 3, or on a read of address 1 that returns code 1.
- R6: The receive-full request clears on a read of address 3. A read of address 1 does not clear it.
- R7: The identification register returns the highest-priority pending source:
  - 3 for an enabled error,
  - 2 for receive-full,
  - 1 for transmit-empty,
  - 0 when nothing is pending.
- R8: Each status bit is set by its strobe and cleared by a read of address 2. An error strobe in the same cycle as that read leaves bit 0 set.
- R9: In block mode, a transmit DMA completion raises `irq_tx`, and `irq_tx` stays high until a status read.
- R10: In block mode, `irq_rx` rises on a receive DMA completion or on an enabled error, with status bits 1 and 0 naming the cause. The word sources raise no request in this mode.
- R11: Both interrupt outputs are flops. An input strobe shows on the outputs at the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_mode | input | 1 | 0 = word mode, 1 = block (DMA) mode |
| thr_empty | input | 1 | Transmit holding register empty level |
| rbr_full | input | 1 | Receive buffer full level |
| tx_dma_done | input | 1 | One-cycle transmit DMA completion strobe |
| rx_dma_done | input | 1 | One-cycle receive DMA completion strobe |
| rx_err | input | 1 | One-cycle receive error strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read has side effects |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; combinational from the address |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |

## Verification
The properties assume the following about the inputs:

- The strobes are single-cycle.
- `bus_wr` and `bus_rd` are never high together.
- A clear at the data address can be judged alone only when the matching status level is low, so that no rising edge races it.

The stimulus drives every input at the falling clock edge and holds each read strobe for exactly one cycle. It drops `thr_empty` and `rbr_full` before it re-arms them, and it changes `dma_mode` only while no strobe is active. The one deliberate same-cycle case is an error arriving during a status read.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_IDENT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_DATA   = 2'd3;

    // Enable and status bit positions
    localparam int BIT_RXF = 0;
    localparam int BIT_TXE = 1;
    localparam int BIT_ERR = 2;

    localparam int ST_ERR = 0;
    localparam int ST_RXD = 1;
    localparam int ST_TXD = 2;

    // Word sources handled by request state machines
    localparam int NSRC    = 2;
    localparam int SRC_RXF = 0;
    localparam int SRC_TXE = 1;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_WAIT = 2'd1,
        SRC_REQ  = 2'd2
    } src_state_e;

    typedef enum logic [1:0] {
        ID_NONE = 2'd0,
        ID_TXE  = 2'd1,
        ID_RXF  = 2'd2,
        ID_ERR  = 2'd3
    } ident_e;

endpackage

// File: rtl/uirq_src_fsm.sv
module uirq_src_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic level,
    input  logic clear,
    output logic req,
    output logic req_nxt
);

    src_state_e state_q;
    src_state_e state_d;
    logic       level_q;
    logic       rise;

    assign rise = level & ~level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRC_OFF;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_OFF: begin
                if (enable) begin
                    state_d = level ? SRC_REQ : SRC_WAIT;
                end
            end
            SRC_WAIT: begin
                if (!enable) begin
                    state_d = SRC_OFF;
                end else if (rise) begin
                    state_d = SRC_REQ;
                end
            end
            SRC_REQ: begin
                if (!enable) begin
                    state_d = SRC_OFF;
                end else if (clear && !rise) begin
                    state_d = SRC_WAIT;
                end
            end
            default: state_d = SRC_OFF;
        endcase
    end

    always_comb begin
        req     = (state_q == SRC_REQ);
        req_nxt = (state_d == SRC_REQ);
    end

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic   err_req,
    input  logic   rxf_req,
    input  logic   txe_req,
    output ident_e ident
);

    always_comb begin
        if (err_req) begin
            ident = ID_ERR;
        end else if (rxf_req) begin
            ident = ID_RXF;
        end else if (txe_req) begin
            ident = ID_TXE;
        end else begin
            ident = ID_NONE;
        end
    end

endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
    import uirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rx_err,
    input  logic              rx_dma_done,
    input  logic              tx_dma_done,
    input  ident_e            ident,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] en_q,
    output logic [2:0]        st_q,
    output logic [2:0]        st_nxt,
    output logic              thr_wr,
    output logic              rbr_rd,
    output logic              iir_rd
);

    localparam int PAD_ID = DATA_W - 2;
    localparam int PAD_ST = DATA_W - 3;

    logic       st_rd;
    logic [2:0] st_set;

    always_comb begin
        thr_wr = bus_wr && (bus_addr == ADR_DATA);
        rbr_rd = bus_rd && (bus_addr == ADR_DATA);
        iir_rd = bus_rd && (bus_addr == ADR_IDENT);
        st_rd  = bus_rd && (bus_addr == ADR_STATUS);
    end

    always_comb begin
        st_set         = '0;
        st_set[ST_ERR] = rx_err;
        st_set[ST_RXD] = rx_dma_done;
        st_set[ST_TXD] = tx_dma_done;
    end

    // A new event in the same cycle as the clearing read wins
    for (genvar g = 0; g < 3; g++) begin : g_status
        assign st_nxt[g] = st_set[g] | (st_q[g] & ~st_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (bus_wr && (bus_addr == ADR_ENABLE)) begin
                en_q <= bus_wdata;
            end
            st_q <= st_nxt;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_ENABLE: bus_rdata = en_q;
            ADR_IDENT:  bus_rdata = {{PAD_ID{1'b0}}, ident};
            ADR_STATUS: bus_rdata = {{PAD_ST{1'b0}}, st_q};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_mode,
    input  logic              thr_empty,
    input  logic              rbr_full,
    input  logic              tx_dma_done,
    input  logic              rx_dma_done,
    input  logic              rx_err,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_rx,
    output logic              irq_tx
);

    logic [DATA_W-1:0] en_q;
    logic [2:0]        st_q;
    logic [2:0]        st_nxt;
    logic              thr_wr;
    logic              rbr_rd;
    logic              iir_rd;
    ident_e            ident;

    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] src_lvl;
    logic [NSRC-1:0] src_clr;
    logic [NSRC-1:0] src_req;
    logic [NSRC-1:0] src_req_nxt;

    logic en_rx;
    logic en_err;
    logic err_q;
    logic err_req;
    logic rx_req;
    logic tx_req;
    logic irq_rx_d;
    logic irq_tx_d;

    uirq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .rx_err      (rx_err),
        .rx_dma_done (rx_dma_done),
        .tx_dma_done (tx_dma_done),
        .ident       (ident),
        .bus_rdata   (bus_rdata),
        .en_q        (en_q),
        .st_q        (st_q),
        .st_nxt      (st_nxt),
        .thr_wr      (thr_wr),
        .rbr_rd      (rbr_rd),
        .iir_rd      (iir_rd)
    );

    always_comb begin
        en_rx   = en_q[BIT_RXF];
        en_err  = en_q[BIT_ERR];
        err_q   = st_q[ST_ERR];
        err_req = err_q & en_err;

        src_en[SRC_RXF]  = en_rx & ~dma_mode;
        src_en[SRC_TXE]  = en_q[BIT_TXE] & ~dma_mode;
        src_lvl[SRC_RXF] = rbr_full;
        src_lvl[SRC_TXE] = thr_empty;
        src_clr[SRC_RXF] = rbr_rd;
        src_clr[SRC_TXE] = thr_wr | (iir_rd && (ident == ID_TXE));
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uirq_src_fsm u_fsm (
            .clk     (clk),
            .rst     (rst),
            .enable  (src_en[g]),
            .level   (src_lvl[g]),
            .clear   (src_clr[g]),
            .req     (src_req[g]),
            .req_nxt (src_req_nxt[g])
        );
    end

    assign rx_req = src_req[SRC_RXF];
    assign tx_req = src_req[SRC_TXE];

    uirq_prio u_prio (
        .err_req (err_req),
        .rxf_req (rx_req),
        .txe_req (tx_req),
        .ident   (ident)
    );

    always_comb begin
        if (dma_mode) begin
            irq_rx_d = st_nxt[ST_RXD] | (st_nxt[ST_ERR] & en_err);
            irq_tx_d = st_nxt[ST_TXD];
        end else begin
            irq_rx_d = (st_nxt[ST_ERR] & en_err) | (|src_req_nxt);
            irq_tx_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_rx <= 1'b0;
            irq_tx <= 1'b0;
        end else begin
            irq_rx <= irq_rx_d;
            irq_tx <= irq_tx_d;
        end
    end

endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk
    import uirq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       dma_mode,
    input logic       thr_empty,
    input logic       rbr_full,
    input logic       tx_dma_done,
    input logic       rx_dma_done,
    input logic       rx_err,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic       irq_rx,
    input logic       irq_tx,
    input logic       en_rx,
    input logic       en_err,
    input logic       rx_req,
    input logic       tx_req,
    input logic       err_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq_rx && !irq_tx && !rx_req && !tx_req && !err_q));

    // R2
    word_tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_mode |=> !irq_tx);

    // R3
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_rx |=> !rx_req);

    // R5
    thr_write_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_DATA && !thr_empty) |=> !tx_req);

    // R6
    rbr_read_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADR_DATA && !rbr_full) |=> !rx_req);

    // R8
    err_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |=> err_q);

    // R9
    dma_tx_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_mode && tx_dma_done) |=> irq_tx);

    // R10
    dma_rx_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_mode && (rx_dma_done || (rx_err && en_err))) |=> irq_rx);

endmodule

bind uirq_ctrl uirq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dma_mode    (dma_mode),
    .thr_empty   (thr_empty),
    .rbr_full    (rbr_full),
    .tx_dma_done (tx_dma_done),
    .rx_dma_done (rx_dma_done),
    .rx_err      (rx_err),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .irq_rx      (irq_rx),
    .irq_tx      (irq_tx),
    .en_rx       (en_rx),
    .en_err      (en_err),
    .rx_req      (rx_req),
    .tx_req      (tx_req),
    .err_q       (err_q)
);

// File: tb/uirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uirq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dma_mode = 1'b0;
    logic       thr_empty = 1'b1;
    logic       rbr_full = 1'b0;
    logic       tx_dma_done = 1'b0;
    logic       rx_dma_done = 1'b0;
    logic       rx_err = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_rx;
    logic       irq_tx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    uirq_ctrl #(.DATA_W(8)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .dma_mode    (dma_mode),
        .thr_empty   (thr_empty),
        .rbr_full    (rbr_full),
        .tx_dma_done (tx_dma_done),
        .rx_dma_done (rx_dma_done),
        .rx_err      (rx_err),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_rx      (irq_rx),
        .irq_tx      (irq_tx)
    );

    // Monitor: pops expected line levels and compares with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({irq_rx, irq_tx} !== e) begin
                bad++;
                $display("FAIL %s irq{rx,tx} actual=%b expected=%b", t, {irq_rx, irq_tx}, e);
            end
        end
    end

    task automatic expect_irq(input logic rx, input logic tx, input string tag);
        repeat (2) @(negedge clk);
        #1;
        exp_q.push_back({rx, tx});
        tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        total++;
        if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s rdata[%0d] actual=%h expected=%h", tag, a, bus_rdata, e);
        end
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk); rx_err = 1'b1;
        @(negedge clk); rx_err = 1'b0;
    endtask

    task automatic pulse_txd();
        @(negedge clk); tx_dma_done = 1'b1;
        @(negedge clk); tx_dma_done = 1'b0;
    endtask

    task automatic pulse_rxd();
        @(negedge clk); rx_dma_done = 1'b1;
        @(negedge clk); rx_dma_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_irq(1'b0, 1'b0, "R1 reset lines");
        read_chk(2'd0, 8'h00, "R1 enable reset");
        read_chk(2'd1, 8'h00, "R1 ident reset");
        read_chk(2'd2, 8'h00, "R1 status reset");
        read_chk(2'd3, 8'h00, "R1 data reads zero");

        // R4 / R2: enable transmit-empty while already empty
        bus_write(2'd0, 8'h02);
        expect_irq(1'b1, 1'b0, "R4 R2 immediate tx on rx line");
        read_chk(2'd0, 8'h02, "R1 enable readback");
        read_chk(2'd1, 8'h01, "R7 ident tx");
        expect_irq(1'b0, 1'b0, "R5 ident read clears tx");
        read_chk(2'd1, 8'h00, "R7 ident none");

        // R3 / R5: rising edge of thr_empty, cleared by data write
        @(negedge clk); thr_empty = 1'b0;
        @(negedge clk); thr_empty = 1'b1;
        expect_irq(1'b1, 1'b0, "R3 tx edge request");
        bus_write(2'd3, 8'h55);
        expect_irq(1'b0, 1'b0, "R5 data write clears tx");
        @(negedge clk); thr_empty = 1'b0;

        // R6: receive-full, not cleared by ident read, cleared by data read
        bus_write(2'd0, 8'h03);
        @(negedge clk); rbr_full = 1'b1;
        expect_irq(1'b1, 1'b0, "R6 rx request");
        read_chk(2'd1, 8'h02, "R7 ident rx");
        expect_irq(1'b1, 1'b0, "R6 ident read keeps rx");
        read_chk(2'd3, 8'h00, "R6 data read");
        expect_irq(1'b0, 1'b0, "R6 data read clears rx");
        @(negedge clk); rbr_full = 1'b0;

        // R3: disabled source ignored
        bus_write(2'd0, 8'h02);
        @(negedge clk); rbr_full = 1'b1;
        expect_irq(1'b0, 1'b0, "R3 disabled rx ignored");
        read_chk(2'd1, 8'h00, "R3 ident stays none");
        @(negedge clk); rbr_full = 1'b0;

        // R7 priority walk
        bus_write(2'd0, 8'h07);
        pulse_err();
        @(negedge clk); rbr_full = 1'b1; thr_empty = 1'b1;
        expect_irq(1'b1, 1'b0, "R2 merged request");
        read_chk(2'd1, 8'h03, "R7 ident error first");
        read_chk(2'd2, 8'h01, "R8 status error bit");
        read_chk(2'd1, 8'h02, "R7 ident rx second");
        read_chk(2'd3, 8'h00, "R6 data read");
        read_chk(2'd1, 8'h01, "R7 ident tx third");
        read_chk(2'd1, 8'h00, "R7 ident empty");
        expect_irq(1'b0, 1'b0, "R7 all serviced");
        @(negedge clk); rbr_full = 1'b0;

        // R8: error in the same cycle as a status read survives
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd2; rx_err = 1'b1;
        #1;
        total++;
        if (bus_rdata !== 8'h00) begin
            bad++;
            $display("FAIL R8 same-cycle read actual=%h expected=%h", bus_rdata, 8'h00);
        end
        @(negedge clk);
        bus_rd = 1'b0; rx_err = 1'b0;
        read_chk(2'd2, 8'h01, "R8 error wins over clear");
        read_chk(2'd2, 8'h00, "R8 read cleared");
        expect_irq(1'b0, 1'b0, "R8 error serviced");

        // R9 / R10: block mode
        @(negedge clk); dma_mode = 1'b1;
        expect_irq(1'b0, 1'b0, "R10 block mode idle");
        pulse_txd();
        expect_irq(1'b0, 1'b1, "R9 tx dma irq");
        read_chk(2'd2, 8'h04, "R9 status tx done");
        expect_irq(1'b0, 1'b0, "R9 cleared by status read");
        pulse_rxd();
        expect_irq(1'b1, 1'b0, "R10 rx dma irq");
        read_chk(2'd2, 8'h02, "R10 cause is completion");
        expect_irq(1'b0, 1'b0, "R10 cleared");
        pulse_err();
        expect_irq(1'b1, 1'b0, "R10 error irq");
        read_chk(2'd2, 8'h01, "R10 cause is error");
        expect_irq(1'b0, 1'b0, "R10 error cleared");
        @(negedge clk); thr_empty = 1'b0;
        @(negedge clk); thr_empty = 1'b1; rbr_full = 1'b1;
        expect_irq(1'b0, 1'b0, "R10 word sources off");
        read_chk(2'd1, 8'h00, "R10 ident none in block mode");

        // R3: error enable off, status still records
        bus_write(2'd0, 8'h03);
        pulse_err();
        expect_irq(1'b0, 1'b0, "R3 error gated");
        read_chk(2'd2, 8'h01, "R3 error still recorded");

        // R11: strobe seen at the first edge that samples it
        @(negedge clk); tx_dma_done = 1'b1;
        @(negedge clk); tx_dma_done = 1'b0;
        total++;
        if (irq_tx !== 1'b1) begin
            bad++;
            $display("FAIL R11 one-edge latency actual=%b expected=1", irq_tx);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule